// File: doc/BRIEF.md
# Interlace Field Detector with Sync Polarity Control

This block tells even video fields from odd ones in an interlaced sync stream. Horizontal and vertical sync come in raw, pass through a synchroniser and are normalised by programmable polarity bits. A counter restarts on every horizontal active edge. The value it holds when the vertical active edge arrives is the field's phase offset. That offset is compared with the offset kept from the previous field to decide the parity of the new field.

A 7-bit writable control register, with the field flag added as a read-only top bit, selects the sync polarities. It also holds four output-inversion controls for the colour, intensity and two auxiliary display outputs, and a dot-row select bit. The dot-row select sets which half-line row of a character cell (row 0 or row 1) the display path draws in each field. The display path uses this to build half-line vertical resolution.

Top module: `field_phase_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, the field flag reads even (0) and `dot_row` is 0.
- R2: Writing `reg_wdata` with `reg_wr_en` high stores bits 6:0, and they read back on `reg_rdata[6:0]`. Bit 7 of `reg_rdata` is the field flag (0 even, 1 odd). A write to bit 7 has no effect on it.
- R3: Bit 0 sets the horizontal sync polarity and bit 1 sets the vertical sync polarity. A value of 0 makes the sync active high, so its rising edge is the active edge. A value of 1 makes it active low, so its falling edge is the active edge.
- R4: The offset counter restarts at every horizontal active edge. The offset of a field is the count reached at that field's vertical active edge, measured from the most recent horizontal active edge.
- R5: If a field's offset is longer than the previous field's offset, the field is even (flag 0). If it is shorter, the field is odd (flag 1).
- R6: If the two offsets are equal, the previous decision is kept. The first field after reset is always even.
- R7: The offset counter is 12 bits wide and stops at 4095. Two offsets that both reach the limit therefore compare equal.
- R8: `dot_row` equals the field flag XOR bit 6. With bit 6 at 0, even fields use row 0 and odd fields use row 1. With bit 6 at 1 the mapping is reversed.
- R9: Output inversion: bit 2 inverts `rgb_out`, bit 3 inverts `aux_out`, bit 4 inverts `ext1_out` and bit 5 inverts `ext2_out`. With a bit at 0, the matching output follows its input unchanged.
- R10: A sync input change sampled at clock edge j is detected after edge j+1. The field flag and `dot_row` take their new values at edge j+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data (bit 7 ignored) |
| reg_rdata | output | 8 | Field flag in bit 7, control bits in 6:0 |
| rgb_in | input | 3 | Colour outputs before polarity |
| rgb_out | output | 3 | Colour outputs after polarity |
| aux_in | input | 2 | Intensity outputs before polarity |
| aux_out | output | 2 | Intensity outputs after polarity |
| ext1_in | input | 1 | First auxiliary output before polarity |
| ext1_out | output | 1 | First auxiliary output after polarity |
| ext2_in | input | 1 | Second auxiliary output before polarity |
| ext2_out | output | 1 | Second auxiliary output after polarity |
| field_odd | output | 1 | Field flag: 0 even, 1 odd |
| dot_row | output | 1 | Half-line dot row for the current field |

## Verification
The assertions assume that the field flag changes only when a vertical active edge is detected. They also assume that a horizontal active edge zeroes the counter on the next cycle. Changing a polarity bit while its sync line is idle makes a false active edge. For this reason the stimulus changes polarity only between fields, moves the raw idle levels to match, and does not check the field that follows. Sync pulses are held for several clocks so the synchroniser cannot miss them.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef struct packed {
    logic dot_sel;
    logic inv_ext2;
    logic inv_ext1;
    logic inv_aux;
    logic inv_rgb;
    logic vs_low;
    logic hs_low;
  } fpc_ctrl_t;

  localparam int unsigned CTRL_W = $bits(fpc_ctrl_t);
endpackage

// File: rtl/fpc_sync_edge.sv
module fpc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic act_low_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              norm;
  logic              norm_q;
  logic              norm_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_comb begin
    norm   = chain_q[STAGES-1] ^ act_low_i;
    norm_d = norm;
    rise_o = norm & ~norm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) norm_q <= 1'b0;
    else        norm_q <= norm_d;
  end

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fpc_phase_judge.sv
module fpc_phase_judge #(
  parameter int unsigned CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_rise_i,
  input  logic v_rise_i,
  output logic field_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] prev_q, prev_d;
  logic [CNT_W-1:0] meas;
  logic             primed_q, primed_d;
  logic             field_q, field_d;
  logic             meas_en;

  always_comb begin
    meas    = h_rise_i ? '0 : cnt_q;
    meas_en = v_rise_i;
    cnt_d   = cnt_q;
    if (h_rise_i)            cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    prev_d   = meas;
    primed_d = 1'b1;
    field_d  = field_q;
    if (!primed_q)          field_d = 1'b0;
    else if (meas > prev_q) field_d = 1'b0;
    else if (meas < prev_q) field_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
      field_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (meas_en) begin
        prev_q   <= prev_d;
        primed_q <= primed_d;
        field_q  <= field_d;
      end
    end
  end

  assign field_o = field_q;

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rise_i |=> cnt_q == '0);

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rise_i |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == CNT_MAX));

  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rise_i |=> $stable(field_o));

  // R5
  field_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rise_i && primed_q && (meas > prev_q)) |=> !field_o);

  // R5
  field_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rise_i && primed_q && (meas < prev_q)) |=> field_o);
endmodule

// File: rtl/fpc_ctrl_reg.sv
module fpc_ctrl_reg
  import fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output fpc_ctrl_t         ctrl_o
);
  fpc_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = fpc_ctrl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_o == $past(wdata));
endmodule

// File: rtl/field_phase_ctrl.sv
module field_phase_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RGB_W       = 3,
  parameter int unsigned AUX_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [RGB_W-1:0] rgb_in,
  output logic [RGB_W-1:0] rgb_out,
  input  logic [AUX_W-1:0] aux_in,
  output logic [AUX_W-1:0] aux_out,
  input  logic             ext1_in,
  output logic             ext1_out,
  input  logic             ext2_in,
  output logic             ext2_out,
  output logic             field_odd,
  output logic             dot_row
);
  logic [1:0] rst_q;
  logic       rst_n_s;
  fpc_ctrl_t  ctrl;
  logic       h_rise;
  logic       v_rise;
  logic       field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  fpc_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata[CTRL_W-1:0]),
    .ctrl_o(ctrl)
  );

  fpc_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .raw_i    (hs_in),
    .act_low_i(ctrl.hs_low),
    .rise_o   (h_rise)
  );

  fpc_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .raw_i    (vs_in),
    .act_low_i(ctrl.vs_low),
    .rise_o   (v_rise)
  );

  fpc_phase_judge #(.CNT_W(CNT_W)) u_judge (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .h_rise_i(h_rise),
    .v_rise_i(v_rise),
    .field_o (field)
  );

  always_comb begin
    reg_rdata = {field, ctrl};
    field_odd = field;
    dot_row   = field ^ ctrl.dot_sel;
    rgb_out   = rgb_in ^ {RGB_W{ctrl.inv_rgb}};
    aux_out   = aux_in ^ {AUX_W{ctrl.inv_aux}};
    ext1_out  = ext1_in ^ ctrl.inv_ext1;
    ext2_out  = ext2_in ^ ctrl.inv_ext2;
  end

  // R10
  field_latency_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $changed(field_odd) |-> $past(v_rise));
endmodule

// File: tb/field_phase_ctrl_bench.sv
module field_phase_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        hl;
    logic        vl;
    logic        sel;
    logic [15:0] gap;
    logic        chk;
    logic        exp;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 16'd100, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd50,  1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 16'd80,  1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'd80,  1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'd30,  1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'd30,  1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd60,  1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd40,  1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 16'd90,  1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd70,  1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd20,  1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_in, vs_in, reg_wr_en;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2:0] rgb_in, rgb_out;
  logic [1:0] aux_in, aux_out;
  logic       ext1_in, ext1_out, ext2_in, ext2_out;
  logic       field_odd, dot_row;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic cur_hl = 1'b0, cur_vl = 1'b0, cur_sel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_phase_ctrl u_field_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rgb_in(rgb_in), .rgb_out(rgb_out), .aux_in(aux_in), .aux_out(aux_out),
    .ext1_in(ext1_in), .ext1_out(ext1_out), .ext2_in(ext2_in), .ext2_out(ext2_out),
    .field_odd(field_odd), .dot_row(dot_row)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic apply_cfg(input logic hl, input logic vl, input logic sel);
    wr_reg({1'b0, sel, 4'b0000, vl, hl});
    cur_sel = sel;
    if (hl != cur_hl || vl != cur_vl) begin
      repeat (4) @(negedge clk);
      hs_in = hl;
      vs_in = vl;
      cur_hl = hl;
      cur_vl = vl;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic h_pulse();
    @(negedge clk) hs_in = ~cur_hl;
    repeat (3) @(negedge clk);
    hs_in = cur_hl;
  endtask

  task automatic v_pulse();
    @(negedge clk) vs_in = ~cur_vl;
    repeat (3) @(negedge clk);
    vs_in = cur_vl;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_field(input int gap);
    h_pulse();
    repeat (gap) @(negedge clk);
    v_pulse();
  endtask

  initial begin
    rst_n = 1'b0; hs_in = 1'b0; vs_in = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    rgb_in = 3'b101; aux_in = 2'b10; ext1_in = 1'b1; ext2_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 field", field_odd, 1'b0);
    check("R1 dot_row", dot_row, 1'b0);
    check("R9 rgb passthrough", rgb_out, 3'b101);

    // Table walk: R3 R5 R6 R8
    for (int i = 0; i < NROWS; i++) begin
      apply_cfg(TBL[i].hl, TBL[i].vl, TBL[i].sel);
      run_field(int'(TBL[i].gap));
      if (TBL[i].chk) begin
        check($sformatf("R5/R6/R3 field row %0d", i), field_odd, TBL[i].exp);
        check($sformatf("R8 dot_row row %0d", i), dot_row, TBL[i].exp ^ TBL[i].sel);
        check($sformatf("R2 rdata7 row %0d", i), reg_rdata[7], TBL[i].exp);
      end
    end

    // Back to positive polarity, prime known state
    apply_cfg(1'b0, 1'b0, 1'b0);
    run_field(60);
    run_field(80);
    check("R5 prime even", field_odd, 1'b0);

    // R10 latency: shorter offset flips to odd two edges after the sampling edge
    h_pulse();
    repeat (10) @(negedge clk);
    vs_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 old value after j+1", field_odd, 1'b0);
    @(negedge clk);
    check("R10 new value after j+2", field_odd, 1'b1);
    check("R10 dot_row after j+2", dot_row, 1'b1);
    repeat (2) @(negedge clk);
    vs_in = 1'b0;
    repeat (8) @(negedge clk);

    // R4 restart at every horizontal edge
    run_field(60);
    check("R4 setup even", field_odd, 1'b0);
    h_pulse();
    repeat (200) @(negedge clk);
    h_pulse();
    repeat (5) @(negedge clk);
    v_pulse();
    check("R4 offset from latest hs", field_odd, 1'b1);

    // R7 saturation: 6000 then 5000 both saturate, decision kept
    run_field(6000);
    check("R7 long field even", field_odd, 1'b0);
    run_field(5000);
    check("R7 saturated equal keeps", field_odd, 1'b0);

    // R2 bit 7 write ignored
    wr_reg(8'h80);
    check("R2 bit7 read-only", reg_rdata, 8'h00);
    wr_reg(8'h40);
    check("R2 readback", reg_rdata, 8'h40);
    check("R8 sel flips row", dot_row, 1'b1);
    wr_reg(8'h00);
    check("R8 sel clear", dot_row, 1'b0);

    // R9 output inversion, one bit at a time
    for (int b = 2; b < 6; b++) begin
      wr_reg(8'(1 << b));
      check($sformatf("R9 rgb bit%0d", b), rgb_out, (b == 2) ? 3'b010 : 3'b101);
      check($sformatf("R9 aux bit%0d", b), aux_out, (b == 3) ? 2'b01 : 2'b10);
      check($sformatf("R9 ext1 bit%0d", b), ext1_out, (b == 4) ? 1'b0 : 1'b1);
      check($sformatf("R9 ext2 bit%0d", b), ext2_out, (b == 5) ? 1'b1 : 1'b0);
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule